// File: doc/BRIEF.md
# Wide-In, Narrow-Out FIFO with Selectable Half Order

This block is a synchronous first-in first-out buffer with one clock for both ports. Its write side accepts 18-bit words and its read side hands them back as 9-bit halves. Two reads therefore drain one stored word. The order of the two halves is chosen once, while master reset is held. In one order the upper half (bits 17:9) comes out first. In the other order the lower half (bits 8:0) comes out first.

An accepted read moves the selected half into an output register. The output bus is driven only when two conditions hold: a read chip select, sampled on the clock, was high on the previous edge, and an output enable, which acts without a clock, is high now. When the bus is not driven, the block signals this with a low valid flag and an all-zero data bus. Empty and full flags report occupancy in whole wide words.

Top module: `width_split_fifo`

## Requirements
- R1: Each accepted write stores one 18-bit word. Each accepted read takes one 9-bit half. A word keeps its storage slot until its second half has been read.
- R2: With `order_sel` high during reset, the halves of each word are read as bits 17:9 first, then bits 8:0.
- R3: With `order_sel` low during reset, the halves of each word are read as bits 8:0 first, then bits 17:9.
- R4: `order_sel` is captured only on clock edges where `rst` is high. Changing it after reset has no effect on the read order.
- R5: `full` is high when `DEPTH` words are held. A write while `full` is high is discarded.
- R6: A read while `empty` is high is discarded, and `rd_data` keeps its value. `empty` rises only after the second half of the last stored word has been read.
- R7: `rd_cs` is registered on the clock. `rd_valid` can become high only on the edge after `rd_cs` was sampled high.
- R8: `out_en` acts without a clock. While it is low, `rd_valid` is 0 and `rd_data` is all-zero. When it returns high, the held half reappears.
- R9: While `rst` is high, the pointers, the half select, the output register and the registered chip select are all cleared. After reset, `empty` = 1, `full` = 0, `rd_valid` = 0 and `rd_data` = 0. The first word written after reset is the first word read.
- R10: The half taken by a read at a clock edge appears on `rd_data` right after that edge. It stays there until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous active-high master reset |
| order_sel | input | 1 | Half order, captured during reset: 1 = upper half first, 0 = lower half first |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Wide word to store |
| rd_en | input | 1 | Read request for one half |
| rd_cs | input | 1 | Read chip select, registered on `clk` |
| out_en | input | 1 | Output enable, takes effect without a clock |
| rd_data | output | 9 | Read half, zero when not driven |
| rd_valid | output | 1 | High when `rd_data` is driven |
| empty | output | 1 | No word, whole or partly read, is held |
| full | output | 1 | All `DEPTH` word slots are occupied |

## Verification
A table of words is pushed and drained in both half orders. Its entries differ between the upper and lower halves, have all bits set or clear, and use patterns that alternate bit by bit, so a swapped order, a shifted slice or a stuck bit each produce a different mismatch. A run that fills the FIFO to capacity and then offers one extra word shows whether the full guard holds, because the extra word must never appear. Reads on an empty FIFO, changes to the order input after reset, toggling of the output enable without a clock edge, and a reset with data still stored each test a corner of the control logic separately.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;

    localparam int unsigned NARROW_W_DEF = 9;
    localparam int unsigned DEPTH_DEF    = 16;

    typedef enum logic {
        ORDER_LOW_FIRST  = 1'b0,
        ORDER_HIGH_FIRST = 1'b1
    } order_e;

    typedef struct packed {
        logic fire;    // an accepted half read this cycle
        logic second;  // the read takes the second half of the word
    } rd_step_t;

    // Decide whether the upper half is the one being taken.
    function automatic logic take_upper(order_e ord, logic second);
        return (ord == ORDER_HIGH_FIRST) ^ second;
    endfunction

endpackage

// File: rtl/wfifo_store.sv
module wfifo_store #(
    parameter int unsigned WORD_W = 18,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_fire,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            slots[wr_addr] <= wr_word;
        end
    end

    assign rd_word = slots[rd_addr];

endmodule

// File: rtl/wfifo_ctrl.sv
module wfifo_ctrl
    import wfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_fire,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output rd_step_t      step,
    output logic          empty,
    output logic          full
);

    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP       = CW'(DEPTH);

    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] used_q;
    logic          half_q;
    logic          rd_fire, word_done;

    assign full      = (used_q == CAP);
    assign empty     = (used_q == '0);
    assign wr_fire   = wr_en & ~full;
    assign rd_fire   = rd_en & ~empty;
    assign word_done = rd_fire & half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            used_q   <= '0;
            half_q   <= 1'b0;
        end else begin
            if (wr_fire) begin
                wr_ptr_q <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
            end
            if (rd_fire) begin
                half_q <= ~half_q;
            end
            if (word_done) begin
                rd_ptr_q <= (rd_ptr_q == LAST_SLOT) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({wr_fire, word_done})
                2'b10:   used_q <= used_q + 1'b1;
                2'b01:   used_q <= used_q - 1'b1;
                default: used_q <= used_q;
            endcase
        end
    end

    assign wr_ptr      = wr_ptr_q;
    assign rd_ptr      = rd_ptr_q;
    assign step.fire   = rd_fire;
    assign step.second = half_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        used_q <= CAP);  // R5

    AST_FULL_HOLDS_WRPTR: assert property (@(posedge clk) disable iff (rst)
        full |=> (wr_ptr_q == $past(wr_ptr_q)));  // R5

    AST_EMPTY_FREEZES_READ: assert property (@(posedge clk) disable iff (rst)
        empty |=> ($stable(rd_ptr_q) && $stable(half_q)));  // R6

    AST_SECOND_HALF_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty && half_q) |=> ($past(rd_ptr_q) != rd_ptr_q || DEPTH == 1));  // R1

endmodule

// File: rtl/wfifo_rdport.sv
module wfifo_rdport
    import wfifo_pkg::*;
#(
    parameter int unsigned NARROW_W = 9,
    localparam int unsigned WORD_W  = 2 * NARROW_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                order_sel,
    input  logic                rd_cs,
    input  logic                out_en,
    input  rd_step_t            step,
    input  logic [WORD_W-1:0]   word,
    output logic [NARROW_W-1:0] rd_data,
    output logic                rd_valid
);

    order_e              order_q;
    logic [NARROW_W-1:0] hold_q;
    logic                cs_q;
    logic                drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            order_q <= order_e'(order_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            cs_q   <= 1'b0;
        end else begin
            cs_q <= rd_cs;
            if (step.fire) begin
                hold_q <= take_upper(order_q, step.second)
                          ? word[WORD_W-1:NARROW_W]
                          : word[NARROW_W-1:0];
            end
        end
    end

    assign drive    = out_en & cs_q;
    assign rd_valid = drive;
    assign rd_data  = drive ? hold_q : '0;

    AST_ORDER_LOCKED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(order_q));  // R4

    AST_VALID_AFTER_CS: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_cs));  // R7

    always_comb begin
        AST_OE_GATES: assert (out_en || !rd_valid);  // R8
    end

endmodule

// File: rtl/width_split_fifo.sv
module width_split_fifo
    import wfifo_pkg::*;
#(
    parameter int unsigned NARROW_W = NARROW_W_DEF,
    parameter int unsigned DEPTH    = DEPTH_DEF,
    localparam int unsigned WORD_W  = 2 * NARROW_W,
    localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                order_sel,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic                rd_cs,
    input  logic                out_en,
    output logic [NARROW_W-1:0] rd_data,
    output logic                rd_valid,
    output logic                empty,
    output logic                full
);

    logic              wr_fire;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    rd_step_t          step;
    logic [WORD_W-1:0] head_word;

    wfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_fire (wr_fire),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .step    (step),
        .empty   (empty),
        .full    (full)
    );

    wfifo_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_fire (wr_fire),
        .wr_addr (wr_ptr),
        .wr_word (wr_data),
        .rd_addr (rd_ptr),
        .rd_word (head_word)
    );

    wfifo_rdport #(.NARROW_W(NARROW_W)) u_rdport (
        .clk       (clk),
        .rst       (rst),
        .order_sel (order_sel),
        .rd_cs     (rd_cs),
        .out_en    (out_en),
        .step      (step),
        .word      (head_word),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    AST_RESET_FLAGS: assert property (@(posedge clk)
        rst |=> (empty && !full && !rd_valid));  // R9

endmodule

// File: tb/width_split_fifo_test.sv
module width_split_fifo_test;

    localparam int DEPTH = 16;
    localparam int NV    = 8;
    localparam logic [17:0] VEC [NV] = '{
        {9'h1A5, 9'h05A}, {9'h000, 9'h1FF}, {9'h1FF, 9'h000}, {9'h155, 9'h0AA},
        {9'h0AA, 9'h155}, {9'h001, 9'h100}, {9'h1FF, 9'h1FF}, {9'h123, 9'h0ED}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       order_sel = 1'b1;
    logic       wr_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rd_cs = 1'b0;
    logic       out_en = 1'b0;
    logic [8:0] rd_data;
    logic       rd_valid, empty, full;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    width_split_fifo #(.NARROW_W(9), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .order_sel(order_sel),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_cs(rd_cs), .out_en(out_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty), .full(full)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic ord);
        @(negedge clk);
        rst = 1'b1;
        order_sel = ord;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [17:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic pop_expect(input logic [8:0] exp, input string tag);
        pop();
        check(rd_data === exp && rd_valid === 1'b1, tag, int'(rd_data), int'(exp));
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [17:0] w;
        // R9: reset state
        do_reset(1'b1);
        #1;
        check(empty === 1'b1, "R9 empty after reset", int'(empty), 1);
        check(full === 1'b0, "R9 full after reset", int'(full), 0);
        check(rd_valid === 1'b0 && rd_data === 9'h000, "R9 output idle", int'(rd_data), 0);

        // R7: registered chip select
        @(negedge clk);
        rd_cs = 1'b1;
        out_en = 1'b1;
        #1;
        check(rd_valid === 1'b0, "R7 valid before edge", int'(rd_valid), 0);
        @(posedge clk);
        #1;
        check(rd_valid === 1'b1, "R7 valid after edge", int'(rd_valid), 1);

        // R2: table, upper half first
        for (int i = 0; i < NV; i++) push(VEC[i]);
        for (int i = 0; i < NV; i++) begin
            pop_expect(VEC[i][17:9], "R2 first half");
            pop_expect(VEC[i][8:0], "R2 second half");
            if (i == NV - 1) check(empty === 1'b1, "R6 empty after last half", int'(empty), 1);
            else             check(empty === 1'b0, "R1 word still held", int'(empty), 0);
        end

        // R6: read on empty ignored
        pop();
        check(rd_data === VEC[NV-1][8:0], "R6 empty read keeps data", int'(rd_data), int'(VEC[NV-1][8:0]));
        check(empty === 1'b1, "R6 empty stays", int'(empty), 1);

        // R4: order input changed after reset has no effect
        @(negedge clk);
        order_sel = 1'b0;
        push({9'h111, 9'h022});
        pop_expect(9'h111, "R4 order locked first");
        check(empty === 1'b0, "R6 half-read word not empty", int'(empty), 0);
        pop_expect(9'h022, "R4 order locked second");

        // R10: data held while idle
        repeat (3) @(posedge clk);
        #1;
        check(rd_data === 9'h022, "R10 data held", int'(rd_data), 9'h022);

        // R8: output enable without clock
        @(negedge clk);
        out_en = 1'b0;
        #1;
        check(rd_valid === 1'b0 && rd_data === 9'h000, "R8 oe low", int'(rd_data), 0);
        out_en = 1'b1;
        #1;
        check(rd_valid === 1'b1 && rd_data === 9'h022, "R8 oe restored", int'(rd_data), 9'h022);

        // R3: table, lower half first
        do_reset(1'b0);
        for (int i = 0; i < NV; i++) push(VEC[i]);
        for (int i = 0; i < NV; i++) begin
            pop_expect(VEC[i][8:0], "R3 first half");
            pop_expect(VEC[i][17:9], "R3 second half");
        end

        // R5: fill, extra write discarded
        do_reset(1'b1);
        for (int i = 0; i < DEPTH; i++) begin
            check(full === 1'b0, "R5 not full yet", int'(full), 0);
            push({9'(i * 3 + 1), 9'(300 - i)});
        end
        check(full === 1'b1, "R5 full at depth", int'(full), 1);
        push(18'h3FFFF);
        check(full === 1'b1, "R5 still full", int'(full), 1);
        for (int i = 0; i < DEPTH; i++) begin
            w = {9'(i * 3 + 1), 9'(300 - i)};
            pop_expect(w[17:9], "R5 drain upper");
            pop_expect(w[8:0], "R5 drain lower");
        end
        check(empty === 1'b1, "R5 extra word dropped", int'(empty), 1);

        // R9: reset with data stored clears pointers
        push({9'h0F0, 9'h00F});
        push({9'h033, 9'h0CC});
        pop();
        do_reset(1'b1);
        #1;
        check(empty === 1'b1 && rd_data === 9'h000, "R9 reset mid-stream", int'(rd_data), 0);
        push({9'h0C3, 9'h13C});
        pop_expect(9'h0C3, "R9 fresh word first");
        pop_expect(9'h13C, "R9 fresh word second");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule